// File: doc/BRIEF.md
# GPIO Transition Interrupt Controller

This block watches two ports of general-purpose input pins, eight on the first port and seven on the second by default. It records every level change on a pin in a sticky per-pin status bit. From the status bits that are enabled, it drives one interrupt output. Each pin passes through a synchronizer before its edges are detected. A pin's level while the block is in reset, and during the first cycles after reset, is taken as the starting level and is not counted as an event. Software reads a port's status by pulsing that port's read strobe. The status value is valid during the strobe cycle, and the register clears at the end of that cycle.

A mode byte sets up the interrupt output. One bit hands a GPIO pad over to the interrupt function and another bit selects which pad. That pad's status bit then always reads zero. Further bits select level or pulse signalling and the idle level of the output. In level mode the output stays active while any enabled status bit is set. In pulse mode the output emits a pulse of a fixed length and repeats it at a fixed interval until every enabled status bit has been cleared by a read. When status is already pending, a new edge on a pin does not start an extra interrupt.

Top module: `gpio_trans_irq`

## Requirements
- R1: A level change on an unmasked pin sets that pin's bit in its port status (`st1_q` bit i = port 1 pin i, `st2_q` bit i = port 2 pin i). With two synchronizer stages, the bit is visible on the third rising clock edge after the pin changes.
- R2: A status bit stays set until its port's read strobe is high at a clock edge. That edge clears the bit.
- R3: If a pin edge reaches the status register on the same clock edge as a read-clear, that pin's bit ends up set. Other bits are cleared.
- R4: The enable registers reset to all zeros. A status bit whose enable is 0 never activates the interrupt. Enables are loaded from `en1_wdata`/`en2_wdata` when `en1_we`/`en2_we` is high.
- R5: The mode byte is loaded from `mode_wdata` on `mode_we`. Bit 7 = 1 turns on the interrupt pad function. Bit 6 selects the pad: 0 selects port 1 top pin, indicated by `irq_loc` = 01; 1 selects port 2 top pin, indicated by `irq_loc` = 10. While the function is on, that pin's status bit reads 0. `irq_loc` is 00 while the function is off.
- R6: Mode bit 4 sets the idle level of `irq_out` (1 = idle high, 0 = idle low), and the active level is its inverse. While mode bit 7 is 0, `irq_out` sits at the idle level.
- R7: With mode bit 5 = 0 (level mode), `irq_out` is active in every cycle in which some enabled status bit is set, and it returns to idle on the cycle after the read that clears the last such bit.
- R8: With mode bit 5 = 1 (pulse mode), `irq_out` goes active one cycle after an enabled status bit becomes set and stays active for PULSE_LEN cycles. The pulse repeats every PULSE_PERIOD cycles while enabled status remains, and no further pulse starts once reads have cleared it.
- R9: A further edge on a pin whose status bit is already set raises no extra interrupt: level mode stays active without a break, and pulse mode adds no pulse outside the repeat schedule.
- R10: After reset, both status values are zero, the mode is zero, `irq_out` is 0 and `irq_loc` is 00, whatever levels the pins held during reset.
- R11: Bit 7 of `st2_q` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p1_pin | input | P1_W | Port 1 pin levels |
| p2_pin | input | P2_W | Port 2 pin levels |
| mode_we | input | 1 | Mode byte write strobe |
| mode_wdata | input | 8 | Mode byte write data |
| en1_we | input | 1 | Port 1 enable write strobe |
| en1_wdata | input | P1_W | Port 1 enable write data |
| en2_we | input | 1 | Port 2 enable write strobe |
| en2_wdata | input | P2_W | Port 2 enable write data |
| st1_rd | input | 1 | Port 1 status read strobe (clears on the edge) |
| st2_rd | input | 1 | Port 2 status read strobe (clears on the edge) |
| st1_q | output | 8 | Port 1 status value |
| st2_q | output | 8 | Port 2 status value |
| irq_out | output | 1 | Interrupt output level |
| irq_loc | output | 2 | Pad taken by the interrupt function |

## Verification
The checker tests the following in every cycle:
- the reserved status bit of port 2;
- the one-hot pad indication and the forced-zero status bit on the selected pad;
- the idle level while the interrupt function is off;
- that status bits are never lost without a read;
- that level mode follows enabled status;
- that no pulse runs longer than PULSE_LEN.

The following need the bench's scenarios:
- the edge-to-status latency;
- an edge that coincides with a read;
- pins held at a level through reset;
- the start cycle and repeat interval of pulses;
- the absence of pulses once status is cleared.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int REG_W = 8;

   // Mode byte; the first member is bit 7
   typedef struct packed {
      logic       irq_fn;     // 7: pad acts as interrupt output
      logic       loc_p2;     // 6: 1 = port 2 top pin, 0 = port 1 top pin
      logic       pulse;      // 5: 1 = pulse signalling, 0 = level
      logic       idle_high;  // 4: idle level of the output
      logic [3:0] spare;      // 3..0: unused by this block
   } irq_mode_t;

endpackage

// File: rtl/gpio_irq_port_stat.sv
module gpio_irq_port_stat #(
   parameter int W           = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin,
   input  logic [W-1:0] mask,
   input  logic         rd,
   output logic [W-1:0] stat_q
);

   logic [W-1:0]           sync_out;
   logic [W-1:0]           prev_q;
   logic [SYNC_STAGES:0]   vld_q;
   logic [W-1:0]           trans;
   logic [W-1:0]           stat_r;

   initial begin
      assert (SYNC_STAGES >= 1) else $fatal(1, "SYNC_STAGES must be at least 1");
      assert (W >= 1)           else $fatal(1, "port width must be at least 1");
   end

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         logic [W-1:0] s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= pin;
         end
         assign sync_out = s_q;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0][W-1:0] s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= {s_q[SYNC_STAGES-2:0], pin};
         end
         assign sync_out = s_q[SYNC_STAGES-1];
      end
   endgenerate

   // valid marker walks down with the first sampled levels
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= '0;
         prev_q <= '0;
      end else begin
         vld_q  <= {vld_q[SYNC_STAGES-1:0], 1'b1};
         prev_q <= sync_out;
      end
   end

   assign trans = vld_q[SYNC_STAGES] ? (sync_out ^ prev_q) : '0;

   // a new edge wins over a simultaneous clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_r <= '0;
      else        stat_r <= ((rd ? '0 : stat_r) | trans) & ~mask;
   end

   assign stat_q = stat_r & ~mask;

endmodule

// File: rtl/gpio_irq_pulse.sv
module gpio_irq_pulse #(
   parameter int PERIOD = 1024,
   parameter int LEN    = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic pending,
   output logic pulse
);

   localparam int CW = $clog2(PERIOD);
   localparam logic [CW-1:0] LAST   = CW'(PERIOD - 1);
   localparam logic [CW-1:0] LEN_C  = CW'(LEN);
   localparam logic [CW-1:0] LEN_M1 = CW'(LEN - 1);

   logic [CW-1:0] pcnt_q;
   logic          run_q;

   initial begin
      assert (LEN >= 1 && LEN < PERIOD) else $fatal(1, "need 1 <= LEN < PERIOD");
      assert (PERIOD >= 2)              else $fatal(1, "PERIOD too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         pcnt_q <= '0;
      end else if (!enable) begin
         run_q  <= 1'b0;
         pcnt_q <= '0;
      end else if (!run_q) begin
         if (pending) begin
            run_q  <= 1'b1;
            pcnt_q <= '0;
         end
      end else if (pcnt_q == LAST) begin
         pcnt_q <= '0;
         run_q  <= pending;
      end else begin
         pcnt_q <= pcnt_q + 1'b1;
         if (!pending && pcnt_q >= LEN_M1) run_q <= 1'b0;
      end
   end

   assign pulse = run_q && (pcnt_q < LEN_C);

endmodule

// File: rtl/gpio_trans_irq.sv
module gpio_trans_irq
   import gpio_irq_pkg::*;
#(
   parameter int P1_W         = 8,
   parameter int P2_W         = 7,
   parameter int SYNC_STAGES  = 2,
   parameter int PULSE_PERIOD = 1024,
   parameter int PULSE_LEN    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [P1_W-1:0]  p1_pin,
   input  logic [P2_W-1:0]  p2_pin,
   input  logic             mode_we,
   input  logic [7:0]       mode_wdata,
   input  logic             en1_we,
   input  logic [P1_W-1:0]  en1_wdata,
   input  logic             en2_we,
   input  logic [P2_W-1:0]  en2_wdata,
   input  logic             st1_rd,
   input  logic             st2_rd,
   output logic [7:0]       st1_q,
   output logic [7:0]       st2_q,
   output logic             irq_out,
   output logic [1:0]       irq_loc
);

   localparam int P1_IRQ = P1_W - 1;
   localparam int P2_IRQ = P2_W - 1;

   irq_mode_t       mode_q;
   logic [P1_W-1:0] en1_q;
   logic [P2_W-1:0] en2_q;
   logic [P1_W-1:0] mask1;
   logic [P2_W-1:0] mask2;
   logic [P1_W-1:0] s1;
   logic [P2_W-1:0] s2;
   logic            pending;
   logic            pulse_act;
   logic            active;

   initial begin
      assert (P1_W >= 1 && P1_W <= REG_W) else $fatal(1, "P1_W out of range");
      assert (P2_W >= 1 && P2_W <  REG_W) else $fatal(1, "P2_W out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         en1_q  <= '0;
         en2_q  <= '0;
      end else begin
         if (mode_we) mode_q <= irq_mode_t'(mode_wdata);
         if (en1_we)  en1_q  <= en1_wdata;
         if (en2_we)  en2_q  <= en2_wdata;
      end
   end

   always_comb begin
      mask1         = '0;
      mask2         = '0;
      mask1[P1_IRQ] = mode_q.irq_fn && !mode_q.loc_p2;
      mask2[P2_IRQ] = mode_q.irq_fn &&  mode_q.loc_p2;
   end

   gpio_irq_port_stat #(.W(P1_W), .SYNC_STAGES(SYNC_STAGES)) u_port1 (
      .clk(clk), .rst_n(rst_n), .pin(p1_pin), .mask(mask1), .rd(st1_rd), .stat_q(s1)
   );

   gpio_irq_port_stat #(.W(P2_W), .SYNC_STAGES(SYNC_STAGES)) u_port2 (
      .clk(clk), .rst_n(rst_n), .pin(p2_pin), .mask(mask2), .rd(st2_rd), .stat_q(s2)
   );

   assign pending = (|(s1 & en1_q)) | (|(s2 & en2_q));

   gpio_irq_pulse #(.PERIOD(PULSE_PERIOD), .LEN(PULSE_LEN)) u_pulse (
      .clk(clk), .rst_n(rst_n), .enable(mode_q.pulse), .pending(pending), .pulse(pulse_act)
   );

   assign active  = mode_q.pulse ? pulse_act : pending;
   assign irq_out = mode_q.irq_fn ? (active ^ mode_q.idle_high) : mode_q.idle_high;
   assign irq_loc = mode_q.irq_fn ? (mode_q.loc_p2 ? 2'b10 : 2'b01) : 2'b00;

   generate
      if (P1_W < REG_W) begin : g_pad1
         assign st1_q = {{(REG_W-P1_W){1'b0}}, s1};
      end else begin : g_full1
         assign st1_q = s1;
      end
   endgenerate

   assign st2_q = {{(REG_W-P2_W){1'b0}}, s2};

endmodule

// File: rtl/gpio_trans_irq_chk.sv
module gpio_trans_irq_chk #(
   parameter int P1_W      = 8,
   parameter int P2_W      = 7,
   parameter int PULSE_LEN = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            mode_we,
   input logic            st1_rd,
   input logic [7:0]      st1_q,
   input logic [7:0]      st2_q,
   input logic            irq_out,
   input logic [1:0]      irq_loc,
   input logic [7:0]      mode_bits,
   input logic [P1_W-1:0] en1_q,
   input logic [P2_W-1:0] en2_q
);

   localparam int CW = $clog2(PULSE_LEN + 2);

   logic          fn, loc2, pmode, idle;
   logic          any_en;
   logic [CW-1:0] act_run;

   assign fn     = mode_bits[7];
   assign loc2   = mode_bits[6];
   assign pmode  = mode_bits[5];
   assign idle   = mode_bits[4];
   assign any_en = (|(st1_q[P1_W-1:0] & en1_q)) | (|(st2_q[P2_W-1:0] & en2_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         act_run <= '0;
      else if (fn && pmode && !mode_we && irq_out != idle) begin
         if (act_run <= CW'(PULSE_LEN)) act_run <= act_run + 1'b1;
      end else
         act_run <= '0;
   end

   p_p2_rsvd_r11: assert property (@(posedge clk) disable iff (!rst_n)
      st2_q[7] == 1'b0);

   p_loc_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_loc));

   p_mask_p1_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fn && !loc2) |-> !st1_q[P1_W-1]);

   p_mask_p2_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fn && loc2) |-> !st2_q[P2_W-1]);

   p_idle_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !fn |-> (irq_out == idle));

   p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!st1_rd && !mode_we) |=> ((st1_q & $past(st1_q)) == $past(st1_q)));

   p_level_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fn && !pmode && any_en) |-> (irq_out != idle));

   p_level_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fn && !pmode && !any_en) |-> (irq_out == idle));

   p_pulse_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      act_run <= CW'(PULSE_LEN));

endmodule

bind gpio_trans_irq gpio_trans_irq_chk #(
   .P1_W(P1_W), .P2_W(P2_W), .PULSE_LEN(PULSE_LEN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .st1_rd(st1_rd),
   .st1_q(st1_q), .st2_q(st2_q), .irq_out(irq_out), .irq_loc(irq_loc),
   .mode_bits(mode_q), .en1_q(en1_q), .en2_q(en2_q)
);

// File: tb/gpio_trans_irq_tb.sv
module gpio_trans_irq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int PER        = 1024;
   localparam int LEN        = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] p1_pin = 8'h00;
   logic [6:0] p2_pin = 7'h00;
   logic       mode_we = 1'b0;
   logic [7:0] mode_wdata = 8'h00;
   logic       en1_we = 1'b0;
   logic [7:0] en1_wdata = 8'h00;
   logic       en2_we = 1'b0;
   logic [6:0] en2_wdata = 7'h00;
   logic       st1_rd = 1'b0;
   logic       st2_rd = 1'b0;
   logic [7:0] st1_q, st2_q;
   logic       irq_out;
   logic [1:0] irq_loc;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // {port1 pins, port2 pins, expected st1, expected st2}
   localparam logic [31:0] VEC [5] = '{
      32'h01_00_01_00, 32'h01_7F_00_7F, 32'hF0_7F_F1_00,
      32'hF0_2A_00_55, 32'h0F_2A_FF_00 };

   gpio_trans_irq #(.P1_W(8), .P2_W(7), .SYNC_STAGES(2),
                    .PULSE_PERIOD(PER), .PULSE_LEN(LEN)) u_dut (
      .clk(clk), .rst_n(rst_n), .p1_pin(p1_pin), .p2_pin(p2_pin),
      .mode_we(mode_we), .mode_wdata(mode_wdata),
      .en1_we(en1_we), .en1_wdata(en1_wdata), .en2_we(en2_we), .en2_wdata(en2_wdata),
      .st1_rd(st1_rd), .st2_rd(st2_rd), .st1_q(st1_q), .st2_q(st2_q),
      .irq_out(irq_out), .irq_loc(irq_loc));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_mode(input logic [7:0] v);
      mode_wdata = v; mode_we = 1'b1; step(1); mode_we = 1'b0;
   endtask

   task automatic wr_en(input logic [7:0] e1, input logic [6:0] e2);
      en1_wdata = e1; en2_wdata = e2; en1_we = 1'b1; en2_we = 1'b1;
      step(1); en1_we = 1'b0; en2_we = 1'b0;
   endtask

   task automatic rd_both;
      st1_rd = 1'b1; st2_rd = 1'b1; step(1); st1_rd = 1'b0; st2_rd = 1'b0;
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
      end
   end

   initial begin
      int first_rise, second_rise, hi_cnt;
      logic last;

      // R10: pins held at nonzero levels through reset
      p1_pin = 8'hA5; p2_pin = 7'h5A;
      step(5); rst_n = 1'b1; step(6);
      chk("R10 st1 after reset", st1_q, 8'h00);
      chk("R10 st2 after reset", st2_q, 8'h00);
      chk("R10 irq_out after reset", irq_out, 1'b0);
      chk("R10 irq_loc after reset", irq_loc, 2'b00);
      p1_pin = 8'h00; p2_pin = 7'h00; step(4);
      chk("R1 st1 falls", st1_q, 8'hA5);
      chk("R1 st2 falls", st2_q, 8'h5A);
      rd_both();

      // table of pin patterns
      for (int i = 0; i < 5; i++) begin
         p1_pin = VEC[i][31:24]; p2_pin = VEC[i][22:16];
         step(4);
         chk("R1 st1 vector", st1_q, VEC[i][15:8]);
         chk("R1 st2 vector", st2_q, {1'b0, VEC[i][6:0]});
         chk("R11 st2 bit7", st2_q[7], 1'b0);
         step(5);
         chk("R2 st1 sticky", st1_q, VEC[i][15:8]);
         rd_both();
         chk("R2 st1 cleared", st1_q, 8'h00);
         chk("R2 st2 cleared", st2_q, 8'h00);
      end

      // R3: edge coincides with read-clear (p1 now 0F)
      p1_pin = 8'h0E; step(4);
      p1_pin = 8'h0C;
      @(posedge clk); @(posedge clk); @(negedge clk);
      st1_rd = 1'b1;
      chk("R2 st1 before clear", st1_q, 8'h01);
      step(1); st1_rd = 1'b0;
      chk("R3 coincident edge kept", st1_q, 8'h02);
      rd_both();

      // R5: pad selection and masking
      wr_mode(8'h80);
      chk("R5 loc port1", irq_loc, 2'b01);
      p1_pin = 8'h8C; step(4);
      chk("R5 masked p1 bit7", st1_q, 8'h00);
      wr_mode(8'hC0);
      chk("R5 loc port2", irq_loc, 2'b10);
      p1_pin = 8'h0C; p2_pin = 7'h6A; step(4);
      chk("R5 masked p2 bit6", st2_q, 8'h00);
      chk("R5 p1 bit7 unmasked", st1_q, 8'h80);
      rd_both();

      // R4 / R7 / R9: level mode
      wr_mode(8'h80);
      wr_en(8'h01, 7'h00);
      p1_pin = 8'h0E; step(4);
      chk("R4 status set", st1_q, 8'h02);
      chk("R4 disabled pin no irq", irq_out, 1'b0);
      p1_pin = 8'h0F; step(4);
      chk("R7 level active", irq_out, 1'b1);
      p1_pin = 8'h0E; step(4);
      chk("R9 status unchanged", st1_q, 8'h03);
      chk("R9 level stays active", irq_out, 1'b1);
      rd_both();
      chk("R7 level released", irq_out, 1'b0);

      // R6: idle polarity
      wr_mode(8'h90);
      chk("R6 idle high", irq_out, 1'b1);
      p1_pin = 8'h0F; step(4);
      chk("R6 active low", irq_out, 1'b0);
      rd_both();
      chk("R6 back to idle high", irq_out, 1'b1);
      wr_mode(8'h10);
      chk("R6 function off idle", irq_out, 1'b1);
      wr_mode(8'h00);
      chk("R6 function off low", irq_out, 1'b0);

      // R4: port 2 enable
      wr_mode(8'h80);
      wr_en(8'h00, 7'h01);
      p2_pin = 7'h6B; step(4);
      chk("R4 port2 enable irq", irq_out, 1'b1);
      rd_both();
      chk("R4 port2 cleared", irq_out, 1'b0);

      // R8 / R9: pulse mode
      wr_en(8'h01, 7'h00);
      wr_mode(8'hA0);
      p1_pin = 8'h0E;
      first_rise = -1; second_rise = -1; hi_cnt = 0; last = 1'b0;
      for (int k = 1; k <= 4 + PER + LEN + 4; k++) begin
         step(1);
         if (irq_out) begin
            hi_cnt++;
            if (!last) begin
               if (first_rise < 0) first_rise = k;
               else if (second_rise < 0) second_rise = k;
            end
         end
         last = irq_out;
         if (k == 100) p1_pin = 8'h0F;
      end
      chk("R8 first pulse start", first_rise, 4);
      chk("R8 repeat interval", second_rise, 4 + PER);
      chk("R9 no extra pulse", hi_cnt, 2 * LEN);
      rd_both();
      hi_cnt = 0;
      for (int k = 0; k < 2 * PER; k++) begin
         step(1);
         if (irq_out) hi_cnt++;
      end
      chk("R8 no pulse after clear", hi_cnt, 0);

      done = 1'b1;
      summary();
   end

endmodule